// File: doc/BRIEF.md
# Dual-Mode Configuration Register Port

This block is the configuration front end of a three-colour video front end. A host writes an 8-bit register file through one of two ports that share the same pins. The first is a three-wire serial port with a clock, a data line and a transfer enable. The second is an 8-bit parallel bus with an active-low strobe, an address/data qualifier and a read/write line. The level on the shared enable/strobe pin at the end of the hardware reset decides which port the block uses. That choice holds until the next hardware reset.

Register addresses are six bits wide. Four addresses hold setup registers, and one address is a software reset. Three address groups of four hold the per-colour offset DAC value, the offset sign and the amplifier gain. In those groups the two low address bits pick red, green or blue, and the fourth code writes all three colours at once. The block samples every pin into its own clock domain, decodes each write and drives the setup fields and the per-colour values as plain outputs.

Top module: `cfg_dual_port`

## Requirements
- R1: On the first clock after `rst_ni` is released, the block latches `sen_stb_i`: 0 selects the serial port and 1 selects the parallel port. `par_mode_o` reports the choice and does not change until the next hardware reset.
- R2: Hardware reset loads these defaults: setup1=03h, setup2=00h, setup3=11h, setup4=00h. It clears every per-colour value, sign and gain to zero.
- R3: A serial frame is a 6-bit address followed by 8 data bits, both sent MSB first. `sdi_dna_i` is sampled on each rising edge of `sck_rnw_i`. A rising edge of `sen_stb_i` writes the data to the addressed register.
- R4: If the number of bits shifted since the previous enable pulse is not exactly 14, the serial frame is dropped when `sen_stb_i` rises, and no register changes.
- R5: In parallel mode a write cycle ends when the strobe `sen_stb_i` rises after a low period, using the values held during that low period. If `sdi_dna_i` was low, `pbus_i[5:0]` becomes the current address. If it was high, `pbus_i` is written to the current address. The address is kept, so several data bytes can follow a single address byte.
- R6: In parallel mode a strobe cycle with `sck_rnw_i` high changes no register and does not change the current address.
- R7: Addresses 1000xx, 1001xx and 1010xx write the DAC value (all 8 bits), the sign (data bit 0) and the gain (data bits 4:0). In xx, 00 is red, 01 is green, 10 is blue and 11 writes all three colours. On the colour outputs, red is lane 0, green is lane 1 and blue is lane 2.
- R8: A write to address 000100 restores every register to its R2 default, whatever the data. It does not re-sample the port selection.
- R9: Writes to the reserved address 000000 and to any address that is not decoded change nothing.
- R10: The setup bits are decoded as follows:
  - setup1 (000001): b0 ADC enable, b1 CDS, b2 monochrome, b6 max-speed mode.
  - setup2 (000010): b0 8-bit output, b2 invert.
  - setup3 (000011): b1:0 clamp level, b5:4 reset-sample adjust, b7:6 monochrome channel.
  - setup4 (000101): b1 DAC range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all pins are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| sen_stb_i | input | 1 | Serial enable (active high) or parallel strobe (active low); port select at reset release |
| sdi_dna_i | input | 1 | Serial data, or parallel address(0)/data(1) qualifier |
| sck_rnw_i | input | 1 | Serial clock, or parallel read(1)/write(0) |
| pbus_i | input | 8 | Parallel byte bus |
| par_mode_o | output | 1 | 1 when the parallel port was selected |
| adc_en_o | output | 1 | setup1 b0 |
| cds_en_o | output | 1 | setup1 b1 |
| mono_o | output | 1 | setup1 b2 |
| max_speed_o | output | 1 | setup1 b6 |
| out8_o | output | 1 | setup2 b0 |
| invert_o | output | 1 | setup2 b2 |
| clamp_sel_o | output | 2 | setup3 b1:0 |
| rs_adj_o | output | 2 | setup3 b5:4 |
| mono_ch_o | output | 2 | setup3 b7:6 |
| dac_range_o | output | 1 | setup4 b1 |
| dac_val_o | output | 24 | DAC values, 8 bits per colour lane |
| dac_neg_o | output | 3 | DAC sign bits, one per colour lane |
| gain_o | output | 15 | Gains, 5 bits per colour lane |

## Verification
Assertions check on every cycle the following:
- the port selection does not change after it is latched;
- the two receivers never write in the same cycle;
- a broadcast leaves the three colour lanes equal;
- a software reset restores the defaults;
- reserved writes leave the setup registers unchanged;
- a parallel cycle with the read line high changes nothing.

The following can only be shown by the bench's scenarios:
- the MSB-first bit order of the serial frame;
- that frames of 13 or 15 bits are dropped;
- that a data byte goes to an address held from an earlier strobe;
- that a software reset keeps the port selection while a hardware reset can change it.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int N_COL   = 3;
  localparam int GAIN_W  = 5;
  localparam int N_SETUP = 4;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int SUB_W   = 2;
  localparam int GRP_W   = ADDR_W - SUB_W;

  localparam logic [ADDR_W-1:0] A_RSVD  = 6'h00;
  localparam logic [ADDR_W-1:0] A_SWRST = 6'h04;

  localparam logic [GRP_W-1:0] G_VAL  = 4'b1000;
  localparam logic [GRP_W-1:0] G_SIGN = 4'b1001;
  localparam logic [GRP_W-1:0] G_GAIN = 4'b1010;
  localparam logic [SUB_W-1:0] SUB_ALL = 2'b11;

  // index 0 = setup1
  localparam logic [N_SETUP-1:0][DATA_W-1:0] DEF_SETUP = {8'h00, 8'h11, 8'h00, 8'h03};

  function automatic logic [ADDR_W-1:0] setup_addr(input int idx);
    case (idx)
      0:       return 6'h01;
      1:       return 6'h02;
      2:       return 6'h03;
      default: return 6'h05;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              sen_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic               sck_d, sen_d, wr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               sck_rise, sen_rise;

  assign sck_rise = en_i && sck_i && !sck_d;
  assign sen_rise = en_i && sen_i && !sen_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      sen_d   <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sck_d <= sck_i;
      sen_d <= sen_i;
      wr_q  <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (sen_rise) begin
        wr_q  <= (cnt_q == CNT_FULL);
        cnt_q <= '0;
      end else if (sck_rise) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wr_o   = wr_q;
  assign addr_o = shreg_q[FRAME_W-1:DATA_W];
  assign data_o = shreg_q[DATA_W-1:0];

  // R4: frame of wrong length never commits
  assert_short_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_rise && cnt_q != CNT_FULL) |=> !wr_o);
  // R3: a commit always restarts the bit count
  assert_count_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_rise |=> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/cfg_parallel_rx.sv
module cfg_parallel_rx
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_ni,
  input  logic              dna_i,
  input  logic              rnw_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              low_seen_q, dna_h, rnw_h, wr_q;
  logic [DATA_W-1:0] bus_h;
  logic [ADDR_W-1:0] addr_q;
  logic              stb_end;

  assign stb_end = en_i && stb_ni && low_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_seen_q <= 1'b0;
      dna_h      <= 1'b0;
      rnw_h      <= 1'b1;
      bus_h      <= '0;
      addr_q     <= '0;
      wr_q       <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (!en_i) begin
        low_seen_q <= 1'b0;
      end else if (!stb_ni) begin
        low_seen_q <= 1'b1;
        bus_h      <= bus_i;
        dna_h      <= dna_i;
        rnw_h      <= rnw_i;
      end else if (low_seen_q) begin
        low_seen_q <= 1'b0;
        if (!rnw_h) begin
          if (!dna_h) addr_q <= bus_h[ADDR_W-1:0];
          else        wr_q   <= 1'b1;
        end
      end
    end
  end

  assign wr_o   = wr_q;
  assign addr_o = addr_q;
  assign data_o = bus_h;

  // R6: read cycles leave address and register file untouched
  assert_read_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_end && rnw_h) |=> (!wr_o && $stable(addr_q)));
  // R5: address byte lands in the held address
  assert_addr_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_end && !rnw_h && !dna_h) |=> (addr_q == $past(bus_h[ADDR_W-1:0])));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [N_SETUP-1:0][DATA_W-1:0]    setup_o,
  output logic [N_COL-1:0][DATA_W-1:0]      val_o,
  output logic [N_COL-1:0]                  neg_o,
  output logic [N_COL-1:0][GAIN_W-1:0]      gain_o
);
  logic [N_SETUP-1:0][DATA_W-1:0] setup_q;
  logic [N_COL-1:0][DATA_W-1:0]   val_q;
  logic [N_COL-1:0]               neg_q;
  logic [N_COL-1:0][GAIN_W-1:0]   gain_q;
  logic soft_rst;

  assign soft_rst = wr_i && (addr_i == A_SWRST);

  for (genvar s = 0; s < N_SETUP; s++) begin : g_setup
    localparam logic [ADDR_W-1:0] MY_ADDR = setup_addr(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            setup_q[s] <= DEF_SETUP[s];
      else if (soft_rst)                      setup_q[s] <= DEF_SETUP[s];
      else if (wr_i && addr_i == MY_ADDR)     setup_q[s] <= data_i;
    end
  end

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    localparam logic [SUB_W-1:0] MY_SUB = SUB_W'(c);
    logic sub_hit;
    assign sub_hit = wr_i && (addr_i[SUB_W-1:0] == MY_SUB || addr_i[SUB_W-1:0] == SUB_ALL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[c]  <= '0;
        neg_q[c]  <= 1'b0;
        gain_q[c] <= '0;
      end else if (soft_rst) begin
        val_q[c]  <= '0;
        neg_q[c]  <= 1'b0;
        gain_q[c] <= '0;
      end else if (sub_hit) begin
        if (addr_i[ADDR_W-1:SUB_W] == G_VAL)  val_q[c]  <= data_i;
        if (addr_i[ADDR_W-1:SUB_W] == G_SIGN) neg_q[c]  <= data_i[0];
        if (addr_i[ADDR_W-1:SUB_W] == G_GAIN) gain_q[c] <= data_i[GAIN_W-1:0];
      end
    end

    if (c > 0) begin : g_bcast_chk
      // R7: broadcast leaves every lane equal to lane 0
      assert_bcast_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i[SUB_W-1:0] == SUB_ALL && addr_i[ADDR_W-1:SUB_W] == G_VAL)
        |=> (val_q[c] == val_q[0]));
    end
  end

  assign setup_o = setup_q;
  assign val_o   = val_q;
  assign neg_o   = neg_q;
  assign gain_o  = gain_q;

  assert_swrst_defaults_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (setup_q == DEF_SETUP && val_q == '0 && neg_q == '0 && gain_q == '0));

  assert_reserved_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RSVD) |=> $stable(setup_q));
endmodule

// File: rtl/cfg_dual_port.sv
module cfg_dual_port
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sen_stb_i,
  input  logic                     sdi_dna_i,
  input  logic                     sck_rnw_i,
  input  logic [DATA_W-1:0]        pbus_i,
  output logic                     par_mode_o,
  output logic                     adc_en_o,
  output logic                     cds_en_o,
  output logic                     mono_o,
  output logic                     max_speed_o,
  output logic                     out8_o,
  output logic                     invert_o,
  output logic [1:0]               clamp_sel_o,
  output logic [1:0]               rs_adj_o,
  output logic [1:0]               mono_ch_o,
  output logic                     dac_range_o,
  output logic [N_COL*DATA_W-1:0]  dac_val_o,
  output logic [N_COL-1:0]         dac_neg_o,
  output logic [N_COL*GAIN_W-1:0]  gain_o
);
  localparam int SYNC_W = DATA_W + 3;

  logic [SYNC_W-1:0] pins_s;
  logic sen_s, sdi_s, sck_s;
  logic [DATA_W-1:0] bus_s;
  logic armed_q, par_mode_q;

  cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sen_stb_i, sdi_dna_i, sck_rnw_i, pbus_i}),
    .q_o   (pins_s)
  );
  assign {sen_s, sdi_s, sck_s, bus_s} = pins_s;

  // port select: first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      par_mode_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q    <= 1'b1;
      par_mode_q <= sen_stb_i;
    end
  end

  logic ser_wr, par_wr;
  logic [ADDR_W-1:0] ser_addr, par_addr;
  logic [DATA_W-1:0] ser_data, par_data;

  cfg_serial_rx u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (armed_q && !par_mode_q),
    .sck_i (sck_s),
    .sdi_i (sdi_s),
    .sen_i (sen_s),
    .wr_o  (ser_wr),
    .addr_o(ser_addr),
    .data_o(ser_data)
  );

  cfg_parallel_rx u_par (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (armed_q && par_mode_q),
    .stb_ni(sen_s),
    .dna_i (sdi_s),
    .rnw_i (sck_s),
    .bus_i (bus_s),
    .wr_o  (par_wr),
    .addr_o(par_addr),
    .data_o(par_data)
  );

  logic [N_SETUP-1:0][DATA_W-1:0] setup;
  logic [N_COL-1:0][DATA_W-1:0]   val;
  logic [N_COL-1:0]               neg;
  logic [N_COL-1:0][GAIN_W-1:0]   gain;

  cfg_regfile u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ser_wr | par_wr),
    .addr_i (par_mode_q ? par_addr : ser_addr),
    .data_i (par_mode_q ? par_data : ser_data),
    .setup_o(setup),
    .val_o  (val),
    .neg_o  (neg),
    .gain_o (gain)
  );

  assign par_mode_o  = par_mode_q;
  assign adc_en_o    = setup[0][0];
  assign cds_en_o    = setup[0][1];
  assign mono_o      = setup[0][2];
  assign max_speed_o = setup[0][6];
  assign out8_o      = setup[1][0];
  assign invert_o    = setup[1][2];
  assign clamp_sel_o = setup[2][1:0];
  assign rs_adj_o    = setup[2][5:4];
  assign mono_ch_o   = setup[2][7:6];
  assign dac_range_o = setup[3][1];
  assign dac_val_o   = val;
  assign dac_neg_o   = neg;
  assign gain_o      = gain;

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(par_mode_q));

  assert_one_writer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ser_wr, par_wr}));
endmodule

// File: tb/cfg_dual_port_bench.sv
`timescale 1ns/1ps
module cfg_dual_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_stb = 1'b0, sdi_dna = 1'b0, sck_rnw = 1'b0;
  logic [7:0] pbus = 8'h00;

  logic par_mode, adc_en, cds_en, mono, max_speed, out8, invert, dac_range;
  logic [1:0] clamp_sel, rs_adj, mono_ch;
  logic [23:0] dac_val;
  logic [2:0]  dac_neg;
  logic [14:0] gain;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cfg_dual_port u_cfg_dual_port (
    .clk_i(clk), .rst_ni(rst_n), .sen_stb_i(sen_stb), .sdi_dna_i(sdi_dna),
    .sck_rnw_i(sck_rnw), .pbus_i(pbus), .par_mode_o(par_mode),
    .adc_en_o(adc_en), .cds_en_o(cds_en), .mono_o(mono), .max_speed_o(max_speed),
    .out8_o(out8), .invert_o(invert), .clamp_sel_o(clamp_sel), .rs_adj_o(rs_adj),
    .mono_ch_o(mono_ch), .dac_range_o(dac_range), .dac_val_o(dac_val),
    .dac_neg_o(dac_neg), .gain_o(gain)
  );

  // observation index: 0-3 setup1..4, 4-6 value r/g/b, 7-9 sign r/g/b, 10-12 gain r/g/b
  function automatic logic [7:0] obs(input int s);
    case (s)
      0: return {1'b0, max_speed, 3'b000, mono, cds_en, adc_en};
      1: return {5'b0, invert, 1'b0, out8};
      2: return {mono_ch, rs_adj, 2'b00, clamp_sel};
      3: return {6'b0, dac_range, 1'b0};
      4, 5, 6:   return dac_val[(s-4)*8 +: 8];
      7, 8, 9:   return {7'b0, dac_neg[s-7]};
      default:   return {3'b0, gain[(s-10)*5 +: 5]};
    endcase
  endfunction

  function automatic logic [7:0] def_obs(input int s);
    if (s == 0) return 8'h03;
    if (s == 2) return 8'h11;
    return 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic hw_reset(input logic sel);
    tick(1);
    sen_stb = sel; sdi_dna = 1'b0; sck_rnw = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
  endtask

  task automatic ser_frame(input logic [5:0] a, input logic [7:0] d, input int nbits);
    logic [13:0] w;
    w = {a, d};
    for (int i = 0; i < nbits; i++) begin
      sdi_dna = (i < 14) ? w[13-i] : 1'b0;
      tick(3); sck_rnw = 1'b1;
      tick(3); sck_rnw = 1'b0;
    end
    tick(2); sen_stb = 1'b1;
    tick(4); sen_stb = 1'b0;
    tick(8);
  endtask

  task automatic par_cycle(input logic dna, input logic rnw, input logic [7:0] b);
    sdi_dna = dna; sck_rnw = rnw; pbus = b;
    tick(3); sen_stb = 1'b0;
    tick(4); sen_stb = 1'b1;
    tick(8);
  endtask

  // {addr, data, observation index, expected}
  localparam logic [25:0] VEC [15] = '{
    {6'h01, 8'h44, 4'd0,  8'h44},  // R3 R10 setup1 fields
    {6'h01, 8'hFF, 4'd0,  8'h47},  // R10 unused setup1 bits dropped
    {6'h02, 8'h05, 4'd1,  8'h05},  // R10 setup2
    {6'h03, 8'hA6, 4'd2,  8'hA2},  // R10 setup3
    {6'h05, 8'h02, 4'd3,  8'h02},  // R10 setup4
    {6'h20, 8'h5A, 4'd4,  8'h5A},  // R7 red value
    {6'h21, 8'h33, 4'd5,  8'h33},  // R7 green value
    {6'h22, 8'hC4, 4'd6,  8'hC4},  // R7 blue value
    {6'h23, 8'h99, 4'd4,  8'h99},  // R7 broadcast value
    {6'h00, 8'h77, 4'd6,  8'h99},  // R9 reserved ignored
    {6'h25, 8'hFF, 4'd8,  8'h01},  // R7 green sign
    {6'h24, 8'h00, 4'd7,  8'h00},  // R7 red sign
    {6'h29, 8'h1F, 4'd11, 8'h1F},  // R7 green gain
    {6'h2B, 8'hEC, 4'd10, 8'h0C},  // R7 broadcast gain, upper bits dropped
    {6'h3F, 8'hFF, 4'd10, 8'h0C}   // R9 undecoded address ignored
  };

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1/R2: serial selection and defaults
    hw_reset(1'b0);
    chk("R1 serial select", {7'b0, par_mode}, 8'h00);
    for (int s = 0; s < 13; s++) chk("R2 default", obs(s), def_obs(s));

    for (int v = 0; v < 15; v++) begin
      ser_frame(VEC[v][25:20], VEC[v][19:12], 14);
      chk($sformatf("R3/R7/R9/R10 vector %0d", v), obs(int'(VEC[v][11:8])), VEC[v][7:0]);
    end
    chk("R7 broadcast blue value", obs(6), 8'h99);
    chk("R7 green sign kept", obs(8), 8'h01);
    chk("R7 broadcast blue gain", obs(12), 8'h0C);

    // R4: 13- and 15-bit frames dropped
    ser_frame(6'h02, 8'h00, 13);
    chk("R4 short frame", obs(1), 8'h05);
    ser_frame(6'h02, 8'h00, 15);
    chk("R4 long frame", obs(1), 8'h05);
    ser_frame(6'h02, 8'h04, 14);
    chk("R3 frame after drop", obs(1), 8'h04);

    // R8: software reset, mode kept
    ser_frame(6'h04, 8'hA5, 14);
    for (int s = 0; s < 13; s++) chk("R8 soft reset default", obs(s), def_obs(s));
    chk("R8 serial mode kept", {7'b0, par_mode}, 8'h00);

    // R1: parallel selection
    hw_reset(1'b1);
    chk("R1 parallel select", {7'b0, par_mode}, 8'h01);
    chk("R2 default after reselect", obs(2), 8'h11);

    // R5: address then data
    par_cycle(1'b0, 1'b0, 8'h03);
    par_cycle(1'b1, 1'b0, 8'h55);
    chk("R5 parallel data write", obs(2), 8'h51);
    // R6: read-strobed data and address ignored
    par_cycle(1'b1, 1'b1, 8'hC0);
    chk("R6 read data ignored", obs(2), 8'h51);
    par_cycle(1'b0, 1'b1, 8'h01);
    par_cycle(1'b1, 1'b0, 8'hB2);
    chk("R6 read address ignored", obs(2), 8'hB2);
    chk("R6 setup1 untouched", obs(0), 8'h03);
    // R5: address held across data bytes
    par_cycle(1'b1, 1'b0, 8'h30);
    chk("R5 address reused", obs(2), 8'h30);
    // R7 via parallel
    par_cycle(1'b0, 1'b0, 8'h22);
    par_cycle(1'b1, 1'b0, 8'h81);
    chk("R7 parallel blue value", obs(6), 8'h81);
    chk("R7 parallel red untouched", obs(4), 8'h00);
    // R8 in parallel mode
    par_cycle(1'b0, 1'b0, 8'h04);
    par_cycle(1'b1, 1'b0, 8'h00);
    chk("R8 parallel soft reset", obs(2), 8'h11);
    chk("R8 parallel soft reset value", obs(6), 8'h00);
    chk("R8 parallel mode kept", {7'b0, par_mode}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule